// File: doc/BRIEF.md
# Keyboard-Controller Host Mailbox Channel

This block is one host interface channel of the kind a keyboard controller uses. It links an external host I/O bus to an internal slave processor. The host writes bytes into an inbound register, and the slave reads them. The slave writes bytes into an outbound register, and the host reads them. A status byte shows both directions at once. It holds an inbound-full flag, an outbound-full flag, a command/data marker and several bits that the slave may set freely.

The host side decodes a 16-bit I/O address and accepts single-cycle read and write strobes. Two ports share one address window, and address bit 2 picks between them:
- Bit 2 = 0 is the data port.
- Bit 2 = 1 is the command/status port.

A host write to either port loads the inbound register. Address bit 2 is recorded as the command/data marker. The inbound-full flag is also the slave's interrupt request, so the slave firmware is told about every host byte. The slave reaches its three registers through a small select field.

Top module: `kbc_mailbox`

## Requirements
- R1: A host strobe takes effect only when address bits 15..4 equal 0x006. Any other address leaves every register unchanged, and a host read of it returns 0x00.
- R2: A host read with address bit 2 = 1 returns the status byte. A host read with address bit 2 = 0 returns the outbound register.
- R3: A decoded host write stores its byte in the inbound register, which the slave reads with select 0.
- R4: Every decoded host write copies address bit 2 into status bit 3 (0 = data, 1 = command). The bit keeps that value until the next decoded host write.
- R5: A decoded host write sets status bit 1 (inbound full) in the following cycle.
- R6: A slave read of the inbound register (select 0) clears status bit 1. If a decoded host write happens in the same cycle, the bit stays 1.
- R7: `slv_irq` is high exactly while status bit 1 is 1.
- R8: A slave write with select 2 updates only status bits 7..4 and bit 2. Bits 3, 1 and 0 are not affected, and the host sees the user bits on status reads.
- R9: A slave write with select 1 loads the outbound register and sets status bit 0. A decoded host read of the data port clears status bit 0.
- R10: While `rst_n` is low, every register, `slv_irq` and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_addr | input | 16 | Host I/O address |
| host_rd | input | 1 | Host I/O read strobe, one cycle |
| host_wr | input | 1 | Host I/O write strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational, 0x00 when not decoded) |
| slv_sel | input | 2 | Slave register select: 0 inbound, 1 outbound, 2 status, 3 none |
| slv_rd | input | 1 | Slave read strobe |
| slv_wr | input | 1 | Slave write strobe |
| slv_wdata | input | 8 | Slave write data |
| slv_rdata | output | 8 | Slave read data (combinational) |
| slv_irq | output | 1 | Interrupt request to the slave, equal to inbound full |

## Verification
The bench builds the block with its defaults:
- 16-bit address.
- 8-bit data.
- Window base 0x006.

With these values the bench can reach:
- Near-miss addresses such as 0x0160 and 0x0164, which differ from a decoded address only above bit 4.
- Both ports of the window.
- All-ones user-bit patterns, which would show any leak into the three flag positions.

A same-cycle host write and slave read of the inbound register is driven directly, and so is a reset asserted in the middle of a run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    SEL_IN   = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } slv_sel_e;

  localparam int unsigned CD_POS  = 3;
  localparam int unsigned IBF_POS = 1;
  localparam int unsigned OBF_POS = 0;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_host_dec.sv
module mbx_host_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-5:0] BASE_HI = 'h006
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              hit,
  output logic              wr_in,
  output logic              cd_bit,
  output logic              rd_out,
  output logic              rd_stat
);
  logic unused_addr_bits;

  assign unused_addr_bits = ^{addr[3], addr[1:0]};

  assign hit     = (addr[ADDR_W-1:4] == BASE_HI);
  assign cd_bit  = addr[2];
  assign wr_in   = hit && wr;
  assign rd_out  = hit && rd && !addr[2];
  assign rd_stat = hit && rd &&  addr[2];

  assert_dec_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_out, rd_stat}));
  assert_dec_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:4] != BASE_HI) |-> !(wr_in || rd_out || rd_stat));
endmodule

// File: rtl/mbx_dregs.sv
module mbx_dregs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_in,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              ld_out,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] out_q
);
  logic [DATA_W-1:0] in_d, out_d;

  always_comb begin
    in_d  = in_q;
    out_d = out_q;
    if (ld_in)  in_d  = host_wdata;
    if (ld_out) out_d = slv_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (ld_in)  in_q  <= in_d;
      if (ld_out) out_q <= out_d;
    end
  end

  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_in |=> $stable(in_q));
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_out |=> $stable(out_q));
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_in,
  input  logic              host_cd,
  input  logic              host_rd_out,
  input  logic              slv_rd_in,
  input  logic              slv_wr_out,
  input  logic              slv_wr_stat,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic [DATA_W-1:0] status
);
  import mbx_pkg::*;

  localparam logic [DATA_W-1:0] FLAG_MASK =
    DATA_W'((1 << CD_POS) | (1 << IBF_POS) | (1 << OBF_POS));
  localparam logic [DATA_W-1:0] USER_MASK = ~FLAG_MASK;

  logic              ibf_q, ibf_d;
  logic              obf_q, obf_d;
  logic              cd_q,  cd_d;
  logic [DATA_W-1:0] user_q, user_d;

  always_comb begin
    ibf_d  = ibf_q;
    obf_d  = obf_q;
    cd_d   = cd_q;
    user_d = user_q;
    if (slv_rd_in)   ibf_d  = 1'b0;
    if (host_wr_in)  ibf_d  = 1'b1;
    if (host_wr_in)  cd_d   = host_cd;
    if (host_rd_out) obf_d  = 1'b0;
    if (slv_wr_out)  obf_d  = 1'b1;
    if (slv_wr_stat) user_d = slv_wdata & USER_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q  <= 1'b0;
      obf_q  <= 1'b0;
      cd_q   <= 1'b0;
      user_q <= '0;
    end else begin
      ibf_q <= ibf_d;
      obf_q <= obf_d;
      if (host_wr_in)  cd_q   <= cd_d;
      if (slv_wr_stat) user_q <= user_d;
    end
  end

  always_comb begin
    status          = user_q;
    status[CD_POS]  = cd_q;
    status[IBF_POS] = ibf_q;
    status[OBF_POS] = obf_q;
  end

  assert_ibf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_in |=> status[IBF_POS]);
  assert_ibf_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_rd_in && !host_wr_in) |=> !status[IBF_POS]);
  assert_cd_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_in |=> (status[CD_POS] == $past(host_cd)));
  assert_obf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slv_wr_out |=> status[OBF_POS]);
  assert_user_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_wr_stat |=> $stable(status & USER_MASK));
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-5:0] BASE_HI = 'h006
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [1:0]        slv_sel,
  input  logic              slv_rd,
  input  logic              slv_wr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic [DATA_W-1:0] slv_rdata,
  output logic              slv_irq
);
  import mbx_pkg::*;

  logic              rst_i_n;
  logic              hit, wr_in, cd_bit, rd_out, rd_stat;
  logic [DATA_W-1:0] in_q, out_q, status;
  slv_sel_e          sel;

  assign sel = slv_sel_e'(slv_sel);

  mbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  mbx_host_dec #(.ADDR_W(ADDR_W), .BASE_HI(BASE_HI)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .hit(hit), .wr_in(wr_in), .cd_bit(cd_bit), .rd_out(rd_out),
    .rd_stat(rd_stat)
  );

  mbx_dregs #(.DATA_W(DATA_W)) u_dregs (
    .clk(clk), .rst_n(rst_i_n),
    .ld_in(wr_in), .host_wdata(host_wdata),
    .ld_out(slv_wr && (sel == SEL_OUT)), .slv_wdata(slv_wdata),
    .in_q(in_q), .out_q(out_q)
  );

  mbx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_i_n),
    .host_wr_in(wr_in), .host_cd(cd_bit), .host_rd_out(rd_out),
    .slv_rd_in(slv_rd && (sel == SEL_IN)),
    .slv_wr_out(slv_wr && (sel == SEL_OUT)),
    .slv_wr_stat(slv_wr && (sel == SEL_STAT)),
    .slv_wdata(slv_wdata), .status(status)
  );

  always_comb begin
    host_rdata = '0;
    if (rd_stat)     host_rdata = status;
    else if (rd_out) host_rdata = out_q;
  end

  always_comb begin
    unique case (sel)
      SEL_IN:   slv_rdata = in_q;
      SEL_OUT:  slv_rdata = out_q;
      SEL_STAT: slv_rdata = status;
      default:  slv_rdata = '0;
    endcase
  end

  assign slv_irq = status[IBF_POS];

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(slv_irq) |-> $past(host_wr && hit));
  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !hit |-> (host_rdata == '0));
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |-> (!slv_irq && status == '0));
endmodule

// File: tb/sim_kbc_mailbox.sv
`timescale 1ns/1ps
module sim_kbc_mailbox;
  localparam int unsigned NV = 21;
  // vector: [40:38] kind, [37:22] addr, [21:20] sel, [19:12] data, [11:4] expect, [3:0] requirement number
  // kind 0 host write, 1 host read+check, 2 slave write, 3 slave read+check, 4 irq check
  localparam logic [40:0] TBL [NV] = '{
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'h00, 4'd10}, // R10 status idle
    {3'd0, 16'h0060, 2'd0, 8'h5A, 8'h00, 4'd3 },
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'h02, 4'd5 }, // R5 IBF set, R4 data
    {3'd4, 16'h0000, 2'd0, 8'h00, 8'h01, 4'd7 }, // R7 irq high
    {3'd3, 16'h0000, 2'd0, 8'h00, 8'h5A, 4'd3 }, // R3 inbound byte
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'h00, 4'd6 }, // R6 cleared
    {3'd4, 16'h0000, 2'd0, 8'h00, 8'h00, 4'd7 }, // R7 irq low
    {3'd0, 16'h0064, 2'd0, 8'hC3, 8'h00, 4'd4 },
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'h0A, 4'd4 }, // R4 command
    {3'd3, 16'h0000, 2'd2, 8'h00, 8'h0A, 4'd8 }, // R8 slave status view
    {3'd2, 16'h0000, 2'd2, 8'hFF, 8'h00, 4'd8 },
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'hFE, 4'd8 }, // R8 user bits only
    {3'd2, 16'h0000, 2'd1, 8'h77, 8'h00, 4'd9 },
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'hFF, 4'd9 }, // R9 OBF set
    {3'd1, 16'h0060, 2'd0, 8'h00, 8'h77, 4'd2 }, // R2 data port
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'hFE, 4'd9 }, // R9 OBF cleared
    {3'd0, 16'h0160, 2'd0, 8'h11, 8'h00, 4'd1 },
    {3'd1, 16'h0164, 2'd0, 8'h00, 8'h00, 4'd1 }, // R1 miss read zero
    {3'd3, 16'h0000, 2'd0, 8'h00, 8'hC3, 4'd1 }, // R1 inbound untouched
    {3'd2, 16'h0000, 2'd2, 8'h00, 8'h00, 4'd8 },
    {3'd1, 16'h0064, 2'd0, 8'h00, 8'h08, 4'd8 }  // R8 user cleared, CD kept
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] host_addr;
  logic        host_rd, host_wr;
  logic [7:0]  host_wdata, host_rdata;
  logic [1:0]  slv_sel;
  logic        slv_rd, slv_wr;
  logic [7:0]  slv_wdata, slv_rdata;
  logic        slv_irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  kbc_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slv_sel(slv_sel), .slv_rd(slv_rd), .slv_wr(slv_wr),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_irq(slv_irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_rd = 0; host_wr = 0; slv_rd = 0; slv_wr = 0;
    host_addr = '0; host_wdata = '0; slv_sel = 2'd3; slv_wdata = '0;
  endtask

  task automatic run_vec(input logic [40:0] v);
    string req;
    req = $sformatf("R%0d", v[3:0]);
    @(negedge clk);
    idle();
    case (v[40:38])
      3'd0: begin host_wr = 1; host_addr = v[37:22]; host_wdata = v[19:12]; end
      3'd1: begin host_rd = 1; host_addr = v[37:22]; end
      3'd2: begin slv_wr = 1; slv_sel = v[21:20]; slv_wdata = v[19:12]; end
      3'd3: begin slv_rd = 1; slv_sel = v[21:20]; end
      default: ;
    endcase
    #1;
    if (v[40:38] == 3'd1) check(host_rdata, v[11:4], req);
    if (v[40:38] == 3'd3) check(slv_rdata, v[11:4], req);
    if (v[40:38] == 3'd4) check({7'd0, slv_irq}, v[11:4], req);
    @(posedge clk);
    #1 idle();
  endtask

  task automatic host_status(input logic [7:0] exp, input string req);
    @(negedge clk);
    idle(); host_rd = 1; host_addr = 16'h0064;
    #1 check(host_rdata, exp, req);
    @(posedge clk);
    #1 idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check(slv_rdata, 8'h00, "R10");
    check({7'd0, slv_irq}, 8'h00, "R10");
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R6 same-cycle host write and slave read: set wins
    @(negedge clk);
    idle();
    host_wr = 1; host_addr = 16'h0060; host_wdata = 8'h99;
    slv_rd = 1; slv_sel = 2'd0;
    #1 check(slv_rdata, 8'hC3, "R6");
    @(posedge clk);
    #1 idle();
    host_status(8'h02, "R6");
    check({7'd0, slv_irq}, 8'h01, "R7");
    run_vec({3'd3, 16'h0000, 2'd0, 8'h00, 8'h99, 4'd3});

    // R4 bit 3 of address is not the port select; write via 0x006C is a command
    run_vec({3'd0, 16'h006C, 2'd0, 8'h42, 8'h00, 4'd4});
    host_status(8'h0A, "R4");

    // R10 reset in mid-run clears all state
    run_vec({3'd2, 16'h0000, 2'd1, 8'h33, 8'h00, 4'd9});
    @(negedge clk) rst_n = 0;
    #1;
    check({7'd0, slv_irq}, 8'h00, "R10");
    slv_sel = 2'd1;
    #1 check(slv_rdata, 8'h00, "R10");
    slv_sel = 2'd0;
    #1 check(slv_rdata, 8'h00, "R10");
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    host_status(8'h00, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule